// File: doc/BRIEF.md
# Quadrature and Pulse Counting Unit

This unit tracks motion or event counts from external phase signals. It holds two 16-bit up/down counters. Each counter decodes a pair of phase inputs in one of three ways: single-edge counting with a separate direction level, double-rate quadrature that reacts only to the second phase, or full-rate quadrature that reacts to every valid phase change. The second counter can take its pair from an alternate set of pins. The two halves can also be joined into one 32-bit counter, which decodes with the second channel's settings.

Software uses a small register port with a one-cycle write strobe and a combinational read. Through it, software chooses the decode modes and the input pair, starts and pauses counting, sets a wrap ceiling for each logical counter, and reads or preloads the count. The phase pins are asynchronous. Each pin passes through a two-flop synchroniser before any edge is detected.

Register map (3-bit address):
- 0: control. Bit 0 runs channel 1. Bit 1 runs channel 2 and the joined counter. Bit 2 joins the halves. Bit 3 moves channel 2 to pins C/D. Bits 5:4 set the channel 1 mode and bits 7:6 set the channel 2 mode. The mode codes are 0 for pulse/direction, 1 for double-rate and 2 for full-rate quadrature.
- 1: channel 1 count.
- 2: channel 2 count.
- 3: the 32-bit joined count, with channel 2 as the upper half.
- 4: channel 1 ceiling.
- 5: channel 2 ceiling.
- 6: joined ceiling.

Top module: `phase_count_unit`

## Requirements
- R1: After reset the control register reads 0 and both counts read 0. The 16-bit ceilings read 0xFFFF and the joined ceiling reads 0xFFFFFFFF.
- R2: In pulse/direction mode (code 0), a rising edge on the first input of the pair steps the count. The step is up when the second input is high and down when it is low. Falling edges do not count.
- R3: In double-rate mode (code 1), only a change of the second input counts. The step is up when the new second-input level equals the first input, and down otherwise.
- R4: In full-rate mode (code 2), a change of exactly one input counts. The first phase leading gives up and the second phase leading gives down. When both inputs change in the same sample, the count does not move.
- R5: Channel 1 always uses pins A/B. Channel 2 uses pins A/B when control bit 3 is 0 and pins C/D when it is 1. The unselected pins have no effect.
- R6: A step up from the ceiling gives 0. A step down from 0 gives the ceiling.
- R7: A ceiling of 0 holds the count at 0 in both directions.
- R8: A count load whose value is above the counter's current ceiling is dropped, and the count keeps its value. A load at or below the ceiling is stored.
- R9: Clearing a run bit freezes that count. Setting it again continues counting from the frozen value.
- R10: When the halves are joined, the counter uses the channel 2 mode, pins and run bit, and the joined ceiling. A carry or borrow out of the low half moves the high half on the same clock edge. Reads at addresses 1, 2 and 3 show the halves of one value.
- R11: A pin change shows up in the count on the third rising clock edge after it, and not on the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_a | input | 1 | Phase input A (asynchronous) |
| pin_b | input | 1 | Phase input B (asynchronous) |
| pin_c | input | 1 | Alternate phase input C (asynchronous) |
| pin_d | input | 1 | Alternate phase input D (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data for `addr` |

## Verification
On every cycle the assertions check the following. A paused channel 1 count stays still. A dropped load leaves it untouched. An up step at the ceiling lands on 0. A zero ceiling keeps the count at 0. A simultaneous change of both phases never produces a quadrature step. Decode direction sequences, the alternate pin selection, the joined carry and borrow and the three-edge latency depend on sequences of pin activity. Only the bench's vector walk and directed cases show those.

// File: rtl/phase_count_unit.sv
module phase_count_unit #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pin_a,
  input  logic           pin_b,
  input  logic           pin_c,
  input  logic           pin_d,
  input  logic           wr_en,
  input  logic [2:0]     addr,
  input  logic [2*W-1:0] wdata,
  output logic [2*W-1:0] rdata
);
  localparam int W2 = 2 * W;
  localparam logic [2:0] AD_CTRL = 3'd0;
  localparam logic [2:0] AD_CNT1 = 3'd1;
  localparam logic [2:0] AD_CNT2 = 3'd2;
  localparam logic [2:0] AD_CNTJ = 3'd3;
  localparam logic [2:0] AD_CEL1 = 3'd4;
  localparam logic [2:0] AD_CEL2 = 3'd5;
  localparam logic [2:0] AD_CELJ = 3'd6;

  logic [3:0] sync1, sync2, prev;
  logic run1, run2, join_en, alt_sel;
  logic [1:0] mode1, mode2;
  logic [W-1:0] cnt_lo, cnt_hi, lo_n, hi_n;
  logic [W-1:0] ceil1, ceil2;
  logic [W2-1:0] ceilj;
  logic [1:0] now1, old1, now2, old2;
  logic st1, up1, st2, up2;

  function automatic logic [1:0] decode(input logic [1:0] mode,
                                        input logic [1:0] cur,
                                        input logic [1:0] old);
    logic ca, cb;
    ca = cur[1] ^ old[1];
    cb = cur[0] ^ old[0];
    case (mode)
      2'd0:    decode = {cur[1] & ~old[1], cur[0]};
      2'd1:    decode = {cb & ~ca, cur[0] == cur[1]};
      default: decode = {ca ^ cb, ca ? (cur[1] != cur[0]) : (cur[0] == cur[1])};
    endcase
  endfunction

  function automatic logic [W-1:0] step_h(input logic [W-1:0] v,
                                          input logic [W-1:0] c,
                                          input logic up);
    if (up) step_h = (v >= c) ? '0 : v + 1'b1;
    else    step_h = (v == '0) ? c : v - 1'b1;
  endfunction

  function automatic logic [W2-1:0] step_f(input logic [W2-1:0] v,
                                           input logic [W2-1:0] c,
                                           input logic up);
    if (up) step_f = (v >= c) ? '0 : v + 1'b1;
    else    step_f = (v == '0) ? c : v - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= {pin_a, pin_b, pin_c, pin_d};
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  assign now1 = sync2[3:2];
  assign old1 = prev[3:2];
  assign now2 = alt_sel ? sync2[1:0] : sync2[3:2];
  assign old2 = alt_sel ? prev[1:0]  : prev[3:2];
  assign {st1, up1} = decode(mode1, now1, old1);
  assign {st2, up2} = decode(mode2, now2, old2);

  always_comb begin
    lo_n = cnt_lo;
    hi_n = cnt_hi;
    if (join_en) begin
      if (run2 && st2) {hi_n, lo_n} = step_f({cnt_hi, cnt_lo}, ceilj, up2);
    end else begin
      if (run1 && st1) lo_n = step_h(cnt_lo, ceil1, up1);
      if (run2 && st2) hi_n = step_h(cnt_hi, ceil2, up2);
    end
    if (wr_en) begin
      case (addr)
        AD_CNT1: if (wdata <= {{W{1'b0}}, ceil1}) lo_n = wdata[W-1:0];
        AD_CNT2: if (wdata <= {{W{1'b0}}, ceil2}) hi_n = wdata[W-1:0];
        AD_CNTJ: if (wdata <= ceilj) {hi_n, lo_n} = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
    end else begin
      cnt_lo <= lo_n;
      cnt_hi <= hi_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run1    <= 1'b0;
      run2    <= 1'b0;
      join_en <= 1'b0;
      alt_sel <= 1'b0;
      mode1   <= 2'd0;
      mode2   <= 2'd0;
      ceil1   <= '1;
      ceil2   <= '1;
      ceilj   <= '1;
    end else if (wr_en) begin
      case (addr)
        AD_CTRL: begin
          run1    <= wdata[0];
          run2    <= wdata[1];
          join_en <= wdata[2];
          alt_sel <= wdata[3];
          mode1   <= wdata[5:4];
          mode2   <= wdata[7:6];
        end
        AD_CEL1: ceil1 <= wdata[W-1:0];
        AD_CEL2: ceil2 <= wdata[W-1:0];
        AD_CELJ: ceilj <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      AD_CTRL: rdata[7:0] = {mode2, mode1, alt_sel, join_en, run2, run1};
      AD_CNT1: rdata[W-1:0] = cnt_lo;
      AD_CNT2: rdata[W-1:0] = cnt_hi;
      AD_CNTJ: rdata = {cnt_hi, cnt_lo};
      AD_CEL1: rdata[W-1:0] = ceil1;
      AD_CEL2: rdata[W-1:0] = ceil2;
      AD_CELJ: rdata = ceilj;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/pcu_props.sv
module pcu_props #(
  parameter int W = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic [2:0]     addr,
  input logic [2*W-1:0] wdata,
  input logic [W-1:0]   cnt_lo,
  input logic [W-1:0]   ceil1,
  input logic           run1,
  input logic           join_en,
  input logic [1:0]     mode1,
  input logic           st1,
  input logic           up1,
  input logic [1:0]     now1,
  input logic [1:0]     old1
);
  a_r9_pause_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!run1 && !join_en && !(wr_en && (addr == 3'd1 || addr == 3'd3)))
    |=> $stable(cnt_lo));

  a_r8_load_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd1 && wdata > {{W{1'b0}}, ceil1} && !run1 && !join_en)
    |=> $stable(cnt_lo));

  a_r6_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!join_en && run1 && st1 && up1 && cnt_lo == ceil1 && !wr_en)
    |=> cnt_lo == '0);

  a_r7_zero_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    (!join_en && ceil1 == '0 && cnt_lo == '0 && !wr_en)
    |=> cnt_lo == '0);

  a_r4_no_double_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mode1 != 2'd0 && now1[1] != old1[1] && now1[0] != old1[0])
    |-> !st1);
endmodule

bind phase_count_unit pcu_props #(.W(W)) u_props (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .cnt_lo(cnt_lo), .ceil1(ceil1), .run1(run1), .join_en(join_en),
  .mode1(mode1), .st1(st1), .up1(up1), .now1(now1), .old1(old1)
);

// File: tb/sim_phase_count_unit.sv
module sim_phase_count_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_a = 1'b0, pin_b = 1'b0, pin_c = 1'b0, pin_d = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  int nchk = 0;
  int nerr = 0;

  always #4 clk = ~clk;

  phase_count_unit u0 (
    .clk(clk), .rst_n(rst_n), .pin_a(pin_a), .pin_b(pin_b), .pin_c(pin_c),
    .pin_d(pin_d), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  // {ctrl, abcd, expected count 1, expected count 2}
  localparam logic [43:0] VEC [21] = '{
    {8'h63, 4'b1000, 16'd1, 16'd0},
    {8'h63, 4'b1100, 16'd2, 16'd1},
    {8'h63, 4'b0100, 16'd3, 16'd1},
    {8'h63, 4'b0000, 16'd4, 16'd2},
    {8'h63, 4'b0100, 16'd3, 16'd1},
    {8'h63, 4'b1100, 16'd2, 16'd1},
    {8'h63, 4'b0000, 16'd2, 16'd1},
    {8'h0B, 4'b1100, 16'd3, 16'd1},
    {8'h0B, 4'b0100, 16'd3, 16'd1},
    {8'h0B, 4'b0101, 16'd3, 16'd1},
    {8'h0B, 4'b0111, 16'd3, 16'd2},
    {8'h0B, 4'b0011, 16'd3, 16'd2},
    {8'h0B, 4'b1001, 16'd2, 16'd2},
    {8'h0B, 4'b0000, 16'd2, 16'd2},
    {8'h0B, 4'b0010, 16'd2, 16'd1},
    {8'h08, 4'b0000, 16'd2, 16'd1},
    {8'h08, 4'b1110, 16'd2, 16'd1},
    {8'h0B, 4'b0000, 16'd2, 16'd1},
    {8'h0B, 4'b1110, 16'd3, 16'd0},
    {8'h0B, 4'b0000, 16'd3, 16'd0},
    {8'h0B, 4'b0010, 16'd3, 16'hFFFF}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic pins(input logic [3:0] p);
    @(negedge clk);
    {pin_a, pin_b, pin_c, pin_d} = p;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_reg(input string tag, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  initial begin
    #(8 * 200000);
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_reg("R1 ctrl", 3'd0, 32'h0);
    expect_reg("R1 cnt1", 3'd1, 32'h0);
    expect_reg("R1 cnt2", 3'd2, 32'h0);
    expect_reg("R1 ceil1", 3'd4, 32'hFFFF);
    expect_reg("R1 ceil2", 3'd5, 32'hFFFF);
    expect_reg("R1 ceilj", 3'd6, 32'hFFFF_FFFF);

    for (int i = 0; i < 21; i++) begin
      string tag;
      if (i < 7) tag = "R3 R4 quadrature";
      else if (i < 15) tag = "R2 R5 pulse/dir";
      else if (i < 20) tag = "R9 pause";
      else tag = "R6 down wrap";
      wr(3'd0, {24'h0, VEC[i][43:36]});
      pins(VEC[i][35:32]);
      expect_reg($sformatf("%s step %0d cnt1", tag, i), 3'd1, {16'h0, VEC[i][31:16]});
      expect_reg($sformatf("%s step %0d cnt2", tag, i), 3'd2, {16'h0, VEC[i][15:0]});
    end

    // R8 loads against ceiling
    wr(3'd0, 32'h01);
    wr(3'd4, 32'd10);
    wr(3'd1, 32'd11);
    expect_reg("R8 load above ceiling dropped", 3'd1, 32'd3);
    wr(3'd1, 32'd10);
    expect_reg("R8 load at ceiling kept", 3'd1, 32'd10);

    // R11 latency then R6 wrap up
    @(negedge clk);
    {pin_a, pin_b, pin_c, pin_d} = 4'b1100;
    repeat (2) @(posedge clk);
    @(negedge clk);
    expect_reg("R11 not yet after two edges", 3'd1, 32'd10);
    @(posedge clk);
    @(negedge clk);
    expect_reg("R11 R6 up wrap on third edge", 3'd1, 32'd0);
    pins(4'b0000);
    pins(4'b1000);
    expect_reg("R6 down from zero to ceiling", 3'd1, 32'd10);

    // R7 zero ceiling
    wr(3'd4, 32'd0);
    wr(3'd1, 32'd0);
    pins(4'b0000);
    pins(4'b1100);
    expect_reg("R7 up with zero ceiling", 3'd1, 32'd0);
    pins(4'b0000);
    pins(4'b1000);
    expect_reg("R7 down with zero ceiling", 3'd1, 32'd0);
    wr(3'd1, 32'd1);
    expect_reg("R8 R7 load 1 over zero ceiling", 3'd1, 32'd0);

    // R10 joined counter on C/D, pulse/direction
    wr(3'd0, 32'h0E);
    wr(3'd3, 32'h0000_FFFF);
    expect_reg("R10 joined load", 3'd3, 32'h0000_FFFF);
    pins(4'b0001);
    pins(4'b0011);
    expect_reg("R10 carry joined", 3'd3, 32'h0001_0000);
    expect_reg("R10 carry low half", 3'd1, 32'h0);
    expect_reg("R10 carry high half", 3'd2, 32'h1);
    pins(4'b0000);
    pins(4'b0010);
    expect_reg("R10 borrow joined", 3'd3, 32'h0000_FFFF);
    wr(3'd3, 32'h0);
    pins(4'b0000);
    pins(4'b0010);
    expect_reg("R10 R6 joined down wrap", 3'd3, 32'hFFFF_FFFF);
    wr(3'd6, 32'h0001_2345);
    wr(3'd3, 32'h0002_0000);
    expect_reg("R10 R8 joined load dropped", 3'd3, 32'hFFFF_FFFF);
    wr(3'd3, 32'h0001_2345);
    expect_reg("R10 R8 joined load kept", 3'd3, 32'h0001_2345);
    pins(4'b0000);
    pins(4'b0011);
    expect_reg("R10 R6 joined up wrap", 3'd3, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule